// File: doc/BRIEF.md
# Key-protected independent watchdog timer

This block is a watchdog that runs from its own slow clock, so it keeps counting even when the system bus clock stops. Software reaches it only through single register writes on a simple bus. Magic 16-bit codes sent to a key location start the watchdog, refresh its counter from a programmable reload value, or open the divider and reload settings for one round of changes. Once started, nothing but a reset stops it. When its 12-bit down-counter runs out, it raises a reset request toward the system reset controller.

Each bus write crosses into the watchdog clock through a toggle handshake. The bus side holds the command steady and shows a busy flag until the watchdog clock has applied it. A board strap sampled during reset can make the watchdog run from power-up with no start code.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0xFFF, the reload value is 0xFFF, the divider select is 0 (divide by 4), the reset request is low, busy is low, and the watchdog is idle unless the strap is high.
- R2: Writes go to offset 0 (key), offset 1 (divider select, data bits 2:0) or offset 2 (reload, data bits 11:0). Writes to any other offset are ignored and do not raise busy. Key 0xCCCC starts an idle watchdog and loads 0xFFF into the counter.
- R3: While running, the counter drops by exactly one on each divider tick. The tick period is 4·2^n watchdog-clock cycles for select n, and any select of 6 or more gives 256.
- R4: When a running counter is at 0x000, the reset request goes high and stays high until reset, even if a refresh follows.
- R5: Key 0xAAAA copies the reload value into the counter, whether the watchdog is idle or running.
- R6: Divider-select and reload writes take effect only while the most recent key was 0x5555. Such writes leave that unlocked state in place.
- R7: Any key other than 0x5555, including 0xAAAA, 0xCCCC and unknown codes, re-locks the divider-select and reload settings.
- R8: No key stops a running watchdog. Key 0xCCCC sent while it is running does not reload the counter.
- R9: With the strap high during reset, the counter runs down from 0xFFF at the default divider with no start code and raises the reset request when it reaches zero.
- R10: Busy reads high in the bus cycle after an accepted write and falls once the watchdog clock has applied the command. Writes made while busy is high are dropped.
- R11: While idle, the counter holds its value, apart from refresh loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Synchronous active-low reset, bus domain |
| wclk | input | 1 | Independent watchdog clock |
| wrst_n | input | 1 | Synchronous active-low reset, watchdog domain |
| hw_start_strap | input | 1 | Starts the watchdog at reset when high |
| bus_we | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| cfg_busy | output | 1 | A written command has not yet reached the watchdog clock |
| wdt_count | output | 12 | Current down-counter value (watchdog domain) |
| wdt_rst_req | output | 1 | Reset request, sticky until reset |

## Verification
The bench targets the lock rules, because a wrong lock would let a stray write change the timeout. A reload write after a refresh, or after an unknown key, must not reach the counter. An unlock must survive a divider write that is followed by a reload write. A second write made while busy is high must vanish, since a design that queued it or overwrote the held data would load the wrong reload value. The bench also checks the following behaviours, each against the failure it catches:
- Sending the start code while running must not push the counter back to 0xFFF.
- Out-of-range divider selects must still give a divide of 256, not 512.
- The reset request must stay high through a late refresh.
- With the strap high, the watchdog must count with no start code and expire close to 4·4095 watchdog-clock cycles after reset.

// File: rtl/kwdt_pkg.sv
// Package: shared constants and types of the key-protected watchdog.
// Assumes a 16-bit key path; bus offsets are fixed so software can find them.
package kwdt_pkg;
    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    localparam int OFF_KEY    = 0;
    localparam int OFF_DIVSEL = 1;
    localparam int OFF_RELOAD = 2;

    typedef enum logic [1:0] {
        CMD_KEY    = 2'd0,
        CMD_DIVSEL = 2'd1,
        CMD_RELOAD = 2'd2
    } cmd_e;
endpackage

// File: rtl/kwdt_sync.sv
// Module: multi-flop synchronizer for a single level or toggle signal.
// Assumes the input changes no faster than STAGES destination clocks.
module kwdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/kwdt_divider.sv
// Module: tick generator that feeds the watchdog down-counter.
// Period is 2^(BASE_LOG2+min(sel,MAX_SEL)) clocks; restart zeroes the phase.
module kwdt_divider #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 2,
    parameter int MAX_SEL   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = BASE_LOG2 + MAX_SEL;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] term;
    int               eff_sel;

    // Clamp the select and form the terminal phase value.
    always_comb begin
        eff_sel = (int'(sel_i) > MAX_SEL) ? MAX_SEL : int'(sel_i);
        term    = DIV_W'((1 << (BASE_LOG2 + eff_sel)) - 1);
    end

    assign tick_o = run_i && !restart_i && (phase_q == term);

    // Advance the phase while running; wrap on tick, zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= '0;
        else if (restart_i) phase_q <= '0;
        else if (tick_o)    phase_q <= '0;
        else if (run_i)     phase_q <= phase_q + 1'b1;
    end

    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && phase_q == term) |=> (phase_q == '0));
endmodule

// File: rtl/kwdt_bus_side.sv
// Module: bus-clock half of the write crossing.
// Captures one write, holds it steady and toggles a request; busy lasts
// until the acknowledge toggle returns. Writes during busy are dropped.
module kwdt_bus_side
    import kwdt_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [KEY_W-1:0]  wdata_i,
    input  logic              ack_tgl_i,
    output logic              req_tgl_o,
    output cmd_e              kind_o,
    output logic [KEY_W-1:0]  data_o,
    output logic              busy_o
);
    logic             ack_s;
    logic             req_q;
    cmd_e             kind_q;
    cmd_e             kind_n;
    logic [KEY_W-1:0] data_q;
    logic             addr_ok;
    logic             accept;

    kwdt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (bclk),
        .rst_n (brst_n),
        .d_i   (ack_tgl_i),
        .q_o   (ack_s)
    );

    assign busy_o = req_q ^ ack_s;

    // Map the offset to a command kind.
    always_comb begin
        addr_ok = 1'b1;
        kind_n  = CMD_KEY;
        if (addr_i == ADDR_W'(OFF_KEY))         kind_n = CMD_KEY;
        else if (addr_i == ADDR_W'(OFF_DIVSEL)) kind_n = CMD_DIVSEL;
        else if (addr_i == ADDR_W'(OFF_RELOAD)) kind_n = CMD_RELOAD;
        else                                    addr_ok = 1'b0;
    end

    assign accept = we_i && addr_ok && !busy_o;

    // Hold an accepted command and flip the request toggle.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            req_q  <= 1'b0;
            kind_q <= CMD_KEY;
            data_q <= '0;
        end else if (accept) begin
            req_q  <= ~req_q;
            kind_q <= kind_n;
            data_q <= wdata_i;
        end
    end

    assign req_tgl_o = req_q;
    assign kind_o    = kind_q;
    assign data_o    = data_q;

    a_r10_busy_after_accept: assert property (@(posedge bclk) disable iff (!brst_n)
        accept |=> busy_o);
    a_r10_hold_while_busy: assert property (@(posedge bclk) disable iff (!brst_n)
        busy_o |=> ($stable(data_q) && $stable(kind_q)));
endmodule

// File: rtl/kwdt_core.sv
// Module: watchdog-clock half: command decode, lock, settings, counter.
// Assumes kind/data are held stable by the bus side while the request
// toggle travels through the synchronizer.
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SEL_W       = 3,
    parameter int BASE_LOG2   = 2,
    parameter int MAX_SEL     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             hw_start_strap,
    input  logic             req_tgl_i,
    input  cmd_e             kind_i,
    input  logic [KEY_W-1:0] data_i,
    output logic             ack_tgl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_req_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic             req_s;
    logic             seen_q;
    logic             fire;
    logic             key_wr;
    logic             is_start;
    logic             is_refresh;
    logic             is_unlock;
    logic             sel_wr;
    logic             rel_wr;
    logic             unlock_q;
    logic             active_q;
    logic             start_load;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic             rst_req_q;

    kwdt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d_i   (req_tgl_i),
        .q_o   (req_s)
    );

    assign fire = req_s ^ seen_q;

    // Record the handled toggle; it doubles as the acknowledge.
    always_ff @(posedge wclk) begin
        if (!wrst_n) seen_q <= 1'b0;
        else         seen_q <= req_s;
    end

    assign ack_tgl_o = seen_q;

    // Decode the command arriving this cycle.
    always_comb begin
        key_wr     = fire && (kind_i == CMD_KEY);
        is_start   = key_wr && (data_i == KEY_START);
        is_refresh = key_wr && (data_i == KEY_REFRESH);
        is_unlock  = key_wr && (data_i == KEY_UNLOCK);
        sel_wr     = fire && (kind_i == CMD_DIVSEL) && unlock_q;
        rel_wr     = fire && (kind_i == CMD_RELOAD) && unlock_q;
        start_load = is_start && !active_q;
        load       = is_refresh || start_load;
        load_val   = is_refresh ? reload_q : CNT_TOP;
    end

    // Unlock follows the most recent key only.
    always_ff @(posedge wclk) begin
        if (!wrst_n)     unlock_q <= 1'b0;
        else if (key_wr) unlock_q <= is_unlock;
    end

    // Protected settings: divider select and reload value.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            sel_q    <= '0;
            reload_q <= CNT_TOP;
        end else begin
            if (sel_wr) sel_q    <= data_i[SEL_W-1:0];
            if (rel_wr) reload_q <= data_i[CNT_W-1:0];
        end
    end

    // Run state: strap at reset or start key; never cleared otherwise.
    always_ff @(posedge wclk) begin
        if (!wrst_n)       active_q <= hw_start_strap;
        else if (is_start) active_q <= 1'b1;
    end

    kwdt_divider #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (BASE_LOG2),
        .MAX_SEL   (MAX_SEL)
    ) u_div (
        .clk       (wclk),
        .rst_n     (wrst_n),
        .run_i     (active_q),
        .restart_i (start_load || sel_wr),
        .sel_i     (sel_q),
        .tick_o    (tick)
    );

    // Down-counter: loads win over ticks; stops at zero.
    always_ff @(posedge wclk) begin
        if (!wrst_n)                              cnt_q <= CNT_TOP;
        else if (load)                            cnt_q <= load_val;
        else if (active_q && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Sticky reset request on expiry.
    always_ff @(posedge wclk) begin
        if (!wrst_n)                        rst_req_q <= 1'b0;
        else if (active_q && cnt_q == '0)   rst_req_q <= 1'b1;
    end

    assign count_o   = cnt_q;
    assign rst_req_o = rst_req_q;

    a_r3_one_step: assert property (@(posedge wclk) disable iff (!wrst_n)
        (active_q && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    a_r11_idle_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!active_q && !load) |=> $stable(cnt_q));
    a_r8_no_stop: assert property (@(posedge wclk) disable iff (!wrst_n)
        active_q |=> active_q);
    a_r4_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
        rst_req_q |=> rst_req_q);
    a_r6_locked_cfg: assert property (@(posedge wclk) disable iff (!wrst_n)
        !unlock_q |=> ($stable(reload_q) && $stable(sel_q)));
endmodule

// File: rtl/keyed_wdt.sv
// Module: top of the key-protected independent watchdog.
// Bus-side capture feeds the watchdog-clock core through a toggle handshake;
// the two clocks are assumed unrelated.
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SEL_W       = 3,
    parameter int BASE_LOG2   = 2,
    parameter int MAX_SEL     = 6,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              hw_start_strap,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic              cfg_busy,
    output logic [CNT_W-1:0]  wdt_count,
    output logic              wdt_rst_req
);
    logic             req_tgl;
    logic             ack_tgl;
    cmd_e             cmd_kind;
    logic [KEY_W-1:0] cmd_data;

    kwdt_bus_side #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bus (
        .bclk      (bclk),
        .brst_n    (brst_n),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .ack_tgl_i (ack_tgl),
        .req_tgl_o (req_tgl),
        .kind_o    (cmd_kind),
        .data_o    (cmd_data),
        .busy_o    (cfg_busy)
    );

    kwdt_core #(
        .CNT_W       (CNT_W),
        .SEL_W       (SEL_W),
        .BASE_LOG2   (BASE_LOG2),
        .MAX_SEL     (MAX_SEL),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_core (
        .wclk           (wclk),
        .wrst_n         (wrst_n),
        .hw_start_strap (hw_start_strap),
        .req_tgl_i      (req_tgl),
        .kind_i         (cmd_kind),
        .data_i         (cmd_data),
        .ack_tgl_o      (ack_tgl),
        .count_o        (wdt_count),
        .rst_req_o      (wdt_rst_req)
    );
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/100ps
module keyed_wdt_tb;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        brst_n = 1'b0;
    logic        wrst_n = 1'b0;
    logic        strap = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy;
    logic [11:0] cnt;
    logic        rreq;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        string tag;
        int    lo;
        int    hi;
        bit    chk_rst;
        bit    rst;
    } exp_t;
    exp_t sbq[$];

    always #2.5 bclk = ~bclk;
    always #7   wclk = ~wclk;

    keyed_wdt u_dut (
        .bclk           (bclk),
        .brst_n         (brst_n),
        .wclk           (wclk),
        .wrst_n         (wrst_n),
        .hw_start_strap (strap),
        .bus_we         (we),
        .bus_addr       (addr),
        .bus_wdata      (wdata),
        .cfg_busy       (busy),
        .wdt_count      (cnt),
        .wdt_rst_req    (rreq)
    );

    task automatic check(string req, bit ok, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            @(negedge bclk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_tests++;
                if (int'(cnt) < e.lo || int'(cnt) > e.hi ||
                    (e.chk_rst && rreq !== e.rst)) begin
                    n_fail++;
                    $display("FAIL %s actual cnt=0x%0h rst=%0b expected cnt=0x%0h..0x%0h rst=%0b",
                             e.tag, cnt, rreq, e.lo, e.hi, e.rst);
                end
            end
        end
    end

    task automatic expect_cnt(string tag, int lo, int hi, bit chk_rst, bit rst);
        exp_t e;
        e.tag = tag; e.lo = lo; e.hi = hi; e.chk_rst = chk_rst; e.rst = rst;
        sbq.push_back(e);
        while (sbq.size() != 0) @(negedge bclk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge bclk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge bclk);
        we = 1'b0;
        while (busy) @(negedge bclk);
    endtask

    task automatic wait_w(int n);
        repeat (n) @(posedge wclk);
        @(negedge bclk);
    endtask

    task automatic do_reset(bit s);
        brst_n = 1'b0; wrst_n = 1'b0; strap = s;
        repeat (4) @(posedge wclk);
        @(negedge wclk) wrst_n = 1'b1;
        @(negedge bclk) brst_n = 1'b1;
        @(negedge bclk);
    endtask

    // Watchdog on the run itself.
    initial begin
        repeat (190000) @(posedge bclk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int prev;
        do_reset(1'b0);
        // R1 reset state
        check("R1 busy", busy == 1'b0, busy, 0);
        expect_cnt("R1 count/rst", 12'hFFF, 12'hFFF, 1'b1, 1'b0);

        // R2 unmapped offset 3 ignored, no busy
        @(negedge bclk); we = 1'b1; addr = 2'd3; wdata = 16'h5555;
        @(negedge bclk); we = 1'b0;
        check("R2 no busy on offset 3", busy == 1'b0, busy, 0);

        // R6 locked reload write ignored; R11 idle holds
        wr(2'd2, 16'h0010);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R6 locked reload ignored", 12'hFFF, 12'hFFF, 1'b1, 1'b0);

        // R5 unlocked reload then refresh
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h0020);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R5 refresh loads reload", 12'h020, 12'h020, 1'b0, 1'b0);

        // R7 refresh re-locked
        wr(2'd2, 16'h0030);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R7 relocked by refresh", 12'h020, 12'h020, 1'b0, 1'b0);

        // R6 unlock persists across two settings writes (select 7 -> clamp)
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0007);
        wr(2'd2, 16'h0040);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R6 unlock persists", 12'h040, 12'h040, 1'b0, 1'b0);

        // R7 unknown key re-locks
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'h0050);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R7 unknown key relocks", 12'h040, 12'h040, 1'b0, 1'b0);

        // R10 busy timing and dropped write
        wr(2'd0, 16'h5555);
        @(negedge bclk); we = 1'b1; addr = 2'd2; wdata = 16'h0060;
        @(negedge bclk);
        check("R10 busy after write", busy == 1'b1, busy, 1);
        wdata = 16'h0070;
        @(negedge bclk); we = 1'b0;
        while (busy) @(negedge bclk);
        check("R10 busy clears", busy == 1'b0, busy, 0);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R10 write during busy dropped", 12'h060, 12'h060, 1'b0, 1'b0);
        wait_w(300);
        expect_cnt("R11 idle count holds", 12'h060, 12'h060, 1'b1, 1'b0);

        // R2 start loads 0xFFF; R3 clamp at 256
        wr(2'd0, 16'hCCCC);
        expect_cnt("R2 start loads top", 12'hFFE, 12'hFFF, 1'b0, 1'b0);
        wait_w(1024);
        expect_cnt("R3 select 7 divides by 256", 12'hFFA, 12'hFFC, 1'b0, 1'b0);

        // R8 start while running does not reload
        prev = int'(cnt);
        wr(2'd0, 16'hCCCC);
        expect_cnt("R8 restart no reload", prev - 1, prev, 1'b0, 1'b0);

        // R8 other key does not stop
        prev = int'(cnt);
        wr(2'd0, 16'h0000);
        wait_w(1024);
        expect_cnt("R8 keeps running", prev - 8, prev - 3, 1'b0, 1'b0);

        // R3 divide by 4
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0100);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R5 running refresh", 12'h0FF, 12'h100, 1'b0, 1'b0);
        wait_w(40);
        expect_cnt("R3 select 0 divides by 4", 12'h0F4, 12'h0F7, 1'b0, 1'b0);

        // R4 expiry and sticky request
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h0008);
        wr(2'd0, 16'hAAAA);
        expect_cnt("R4 before expiry", 12'h007, 12'h008, 1'b1, 1'b0);
        wait_w(45);
        expect_cnt("R4 request at zero", 12'h000, 12'h000, 1'b1, 1'b1);
        wr(2'd0, 16'hAAAA);
        wait_w(2);
        check("R4 request sticky", rreq == 1'b1, rreq, 1);

        // R9 strap-started watchdog, R1 after second reset
        do_reset(1'b1);
        expect_cnt("R9 strap start near top", 12'hFFD, 12'hFFF, 1'b1, 1'b0);
        wait_w(100);
        expect_cnt("R9 runs without start key", 12'hFFF - 27, 12'hFFF - 23, 1'b1, 1'b0);
        begin
            int n;
            n = 0;
            while (!rreq && n < 17000) begin
                @(posedge wclk);
                n++;
            end
            @(negedge bclk);
            check("R9 expiry time", n >= 16150 && n <= 16400, n, 16280);
            check("R9 request raised", rreq == 1'b1, rreq, 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule